// File: doc/BRIEF.md
# Memory Fence Ordering Unit

This unit sits between one in-order source of memory requests and a memory port that may keep several loads and stores in flight and finish them in any order. Loads and stores pass straight through to the issue port in the same cycle, with no stall, while the unit keeps separate counts of how many of each class are still outstanding. Completion pulses tagged load or store decrement those counts.

A fence request never reaches memory. It names which earlier accesses it orders: all of them, only loads, or only stores. While the selected count is non-zero, the fence is not accepted. Because the input is in order, every request behind it waits too. Once the count drains, the fence retires inside the unit and the next request flows. A typical use is a store-only fence between a data store and the store that publishes a pointer to that data. It makes sure the data write has finished before the pointer write goes out.

Top module: `mem_fence_unit`

## Requirements
- R1: A load (`req_kind`=0) or store (`req_kind`=1) whose class count is below the limit drives `iss_valid` high in the same cycle, with `iss_is_store` equal to `req_kind[0]` and the payload passed through. `req_ready` then equals `iss_ready`.
- R2: A full fence (`req_kind[1]`=1, `req_fence_sel` 0 or 3) is accepted only in a cycle in which both the load count and the store count are zero.
- R3: A load-only fence (`req_fence_sel`=1) is accepted once the load count is zero, even while stores remain outstanding.
- R4: A store-only fence (`req_fence_sel`=2) is accepted once the store count is zero, even while loads remain outstanding.
- R5: A fence request never raises `iss_valid`.
- R6: Loads and stores are counted separately, up to CNT_MAX (16). While a class holds CNT_MAX outstanding accesses, a request of that class gets neither `iss_valid` nor `req_ready`. The other class still issues.
- R7: An issue and a completion of the same class in one cycle leave that class's count unchanged.
- R8: A fence whose condition already holds when it is presented is accepted in that same cycle.
- R9: After reset both counts are zero, so a full fence retires immediately and no issue is asked for while the input is idle.
- R10: For the sequence store, store-only fence, store, the second store is not offered to memory until the first store's completion has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_kind | input | 2 | 0 load, 1 store, 2 or 3 fence |
| req_fence_sel | input | 2 | Fence scope: 0 or 3 all, 1 loads, 2 stores |
| req_payload | input | PAY_W | Address/data bundle carried to memory |
| iss_valid | output | 1 | Access offered to memory |
| iss_ready | input | 1 | Memory takes the access |
| iss_is_store | output | 1 | 1 for store, 0 for load |
| iss_payload | output | PAY_W | Payload of the offered access |
| cpl_load | input | 1 | One load finished |
| cpl_store | input | 1 | One store finished |

## Verification
The assertions assume that memory never reports a completion for a class that has nothing outstanding. They also assume that a request that is not accepted stays on the input unchanged. The bench keeps its own outstanding counts and raises a completion pulse only when the matching count is positive. It holds each refused request constant until the cycle in which it is accepted. The assertions also rely on the counts being updated only by accepted issues. The bench therefore counts an issue only in a cycle where `iss_valid` and `iss_ready` are both high.

// File: rtl/fence_pkg.sv
package fence_pkg;
  typedef enum logic [1:0] {
    KIND_LOAD   = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_FENCE  = 2'd2,
    KIND_FENCE2 = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    SCOPE_ALL    = 2'd0,
    SCOPE_LOADS  = 2'd1,
    SCOPE_STORES = 2'd2,
    SCOPE_ALL2   = 2'd3
  } fence_scope_e;

  localparam int unsigned NCLS = 2;  // index 0 loads, 1 stores
endpackage

// File: rtl/fence_rst_sync.sv
module fence_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/fence_ctr.sv
module fence_ctr #(
  parameter int unsigned CNT_MAX = 16,
  localparam int unsigned CW = $clog2(CNT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = inc ^ dec;
    cnt_d  = cnt_q;
    if (inc && !dec)      cnt_d = cnt_q + CW'(1);
    else if (dec && !inc) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt   = cnt_q;
  assign full  = (cnt_q == CW'(CNT_MAX));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/fence_gate.sv
module fence_gate
  import fence_pkg::*;
(
  input  logic            req_valid,
  input  logic [1:0]      req_kind,
  input  logic [1:0]      req_fence_sel,
  input  logic            iss_ready,
  input  logic [NCLS-1:0] cls_full,
  input  logic [NCLS-1:0] cls_empty,
  output logic            iss_valid,
  output logic            req_ready,
  output logic [NCLS-1:0] iss_fire
);
  logic is_fence, cls, mem_ok, fence_ok;

  always_comb begin
    is_fence = req_kind[1];
    cls      = req_kind[0];
    mem_ok   = !cls_full[cls];
    unique case (fence_scope_e'(req_fence_sel))
      SCOPE_LOADS:  fence_ok = cls_empty[0];
      SCOPE_STORES: fence_ok = cls_empty[1];
      default:      fence_ok = &cls_empty;
    endcase
    iss_valid = req_valid && !is_fence && mem_ok;
    req_ready = is_fence ? fence_ok : (mem_ok && iss_ready);
    for (int c = 0; c < NCLS; c++) begin
      iss_fire[c] = iss_valid && iss_ready && (cls == c[0]);
    end
  end
endmodule

// File: rtl/mem_fence_unit.sv
module mem_fence_unit
  import fence_pkg::*;
#(
  parameter int unsigned CNT_MAX = 16,
  parameter int unsigned PAY_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [1:0]       req_fence_sel,
  input  logic [PAY_W-1:0] req_payload,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic             iss_is_store,
  output logic [PAY_W-1:0] iss_payload,
  input  logic             cpl_load,
  input  logic             cpl_store
);
  localparam int unsigned CW = $clog2(CNT_MAX + 1);

  logic            rst_n_s;
  logic [NCLS-1:0] fire, done, full, empty;
  logic [CW-1:0]   cnt_q [NCLS];

  fence_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  assign done = {cpl_store, cpl_load};

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    fence_ctr #(.CNT_MAX(CNT_MAX)) u_ctr (
      .clk(clk), .rst_n(rst_n_s), .inc(fire[c]), .dec(done[c]),
      .cnt(cnt_q[c]), .full(full[c]), .empty(empty[c])
    );
  end

  fence_gate u_gate (
    .req_valid(req_valid), .req_kind(req_kind), .req_fence_sel(req_fence_sel),
    .iss_ready(iss_ready), .cls_full(full), .cls_empty(empty),
    .iss_valid(iss_valid), .req_ready(req_ready), .iss_fire(fire)
  );

  assign iss_is_store = req_kind[0];
  assign iss_payload  = req_payload;
endmodule

// File: rtl/fence_unit_checker.sv
module fence_unit_checker #(
  parameter int unsigned CNT_MAX = 16,
  localparam int unsigned CW = $clog2(CNT_MAX + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_kind,
  input logic [1:0]    req_fence_sel,
  input logic          iss_valid,
  input logic          iss_ready,
  input logic          iss_is_store,
  input logic          cpl_load,
  input logic          cpl_store,
  input logic [CW-1:0] ld_cnt,
  input logic [CW-1:0] st_cnt
);
  logic fence_all, fence_ld, fence_st, is_mem;
  assign is_mem    = req_valid && !req_kind[1];
  assign fence_all = req_valid && req_kind[1] && (req_fence_sel == 2'd0 || req_fence_sel == 2'd3);
  assign fence_ld  = req_valid && req_kind[1] && (req_fence_sel == 2'd1);
  assign fence_st  = req_valid && req_kind[1] && (req_fence_sel == 2'd2);

  p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    is_mem && ((req_kind[0] ? st_cnt : ld_cnt) < CW'(CNT_MAX)) |-> iss_valid && (iss_is_store == req_kind[0]));

  p_full_fence_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fence_all && req_ready |-> (ld_cnt == '0) && (st_cnt == '0));

  p_load_fence_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fence_ld && req_ready |-> ld_cnt == '0);

  p_store_fence_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fence_st && req_ready |-> st_cnt == '0);

  p_fence_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind[1] |-> !iss_valid);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_cnt <= CW'(CNT_MAX)) && (st_cnt <= CW'(CNT_MAX)));

  p_full_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_mem && !req_kind[0] && ld_cnt == CW'(CNT_MAX) |-> !iss_valid && !req_ready);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_ready && !iss_is_store && cpl_load |=> ld_cnt == $past(ld_cnt));

  p_same_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fence_ld && ld_cnt == '0 |-> req_ready);
endmodule

bind mem_fence_unit fence_unit_checker #(.CNT_MAX(CNT_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .req_valid(req_valid), .req_ready(req_ready),
  .req_kind(req_kind), .req_fence_sel(req_fence_sel), .iss_valid(iss_valid),
  .iss_ready(iss_ready), .iss_is_store(iss_is_store), .cpl_load(cpl_load),
  .cpl_store(cpl_store), .ld_cnt(cnt_q[0]), .st_cnt(cnt_q[1])
);

// File: tb/tb_mem_fence_unit.sv
`timescale 1ns/100ps
module tb_mem_fence_unit;
  localparam int MAXC = 16;
  localparam int PW   = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_kind = 2'd0;
  logic [1:0]    req_fence_sel = 2'd0;
  logic [PW-1:0] req_payload = '0;
  logic          iss_valid;
  logic          iss_ready = 1'b0;
  logic          iss_is_store;
  logic [PW-1:0] iss_payload;
  logic          cpl_load = 1'b0;
  logic          cpl_store = 1'b0;

  int checks = 0;
  int errors = 0;
  int ocnt[2] = '{0, 0};
  bit last_acc;
  bit last_iv;
  bit last_rdy;

  always #2.5 clk = ~clk;

  mem_fence_unit #(.CNT_MAX(MAXC), .PAY_W(PW)) dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input bit v, input logic [1:0] k, input logic [1:0] s);
    if (v && k[1]) begin
      if (s == 2'd1) return "R3";
      if (s == 2'd2) return "R4";
      return "R2";
    end
    if (v && ocnt[k[0]] >= MAXC) return "R6";
    return "R1";
  endfunction

  // One cycle: drive, compare with model, advance model.
  task automatic step(input bit v, input logic [1:0] k, input logic [1:0] s,
                      input logic [PW-1:0] p, input bit ir, input bit cl, input bit cs);
    bit exp_iv, exp_rdy, fence_ok;
    string tg;
    req_valid = v; req_kind = k; req_fence_sel = s; req_payload = p;
    iss_ready = ir; cpl_load = cl; cpl_store = cs;
    #1;
    tg = tag_of(v, k, s);
    if (s == 2'd1)      fence_ok = (ocnt[0] == 0);
    else if (s == 2'd2) fence_ok = (ocnt[1] == 0);
    else                fence_ok = (ocnt[0] == 0) && (ocnt[1] == 0);
    exp_iv  = v && !k[1] && (ocnt[k[0]] < MAXC);
    exp_rdy = k[1] ? fence_ok : ((ocnt[k[0]] < MAXC) && ir);
    chk(iss_valid === exp_iv, v && k[1] ? "R5" : tg, int'(iss_valid), int'(exp_iv));
    if (v) chk(req_ready === exp_rdy, tg, int'(req_ready), int'(exp_rdy));
    if (exp_iv) begin
      chk(iss_is_store === k[0], "R1", int'(iss_is_store), int'(k[0]));
      chk(iss_payload === p, "R1", int'(iss_payload), int'(p));
    end
    last_iv  = iss_valid;
    last_rdy = req_ready;
    last_acc = v && exp_rdy;
    if (exp_iv && ir) ocnt[k[0]]++;
    if (cl) ocnt[0]--;
    if (cs) ocnt[1]--;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 2'd0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    bit v; logic [1:0] k, s; logic [PW-1:0] p;
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state
    step(1'b0, 2'd0, 2'd0, '0, 1'b1, 1'b0, 1'b0);
    chk(last_iv == 1'b0, "R9", int'(last_iv), 0);
    step(1'b1, 2'd2, 2'd0, '0, 1'b1, 1'b0, 1'b0);
    chk(last_rdy == 1'b1, "R9", int'(last_rdy), 1);

    // R10: store, store-only fence, store
    step(1'b1, 2'd1, 2'd0, 32'hDA7A, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 2'd2, 2'd2, '0, 1'b1, 1'b0, 1'b0);
      chk(last_rdy == 1'b0, "R10", int'(last_rdy), 0);
      chk(last_iv == 1'b0, "R10", int'(last_iv), 0);
    end
    step(1'b1, 2'd2, 2'd2, '0, 1'b1, 1'b0, 1'b1);
    chk(last_rdy == 1'b0, "R10", int'(last_rdy), 0);
    step(1'b1, 2'd2, 2'd2, '0, 1'b1, 1'b0, 1'b0);
    chk(last_rdy == 1'b1, "R10", int'(last_rdy), 1);
    step(1'b1, 2'd1, 2'd0, 32'h0BB0, 1'b1, 1'b0, 1'b0);
    chk(last_iv == 1'b1, "R10", int'(last_iv), 1);

    // R3 with store outstanding, R4 with load outstanding
    step(1'b1, 2'd0, 2'd0, 32'h10, 1'b1, 1'b0, 1'b0);
    step(1'b1, 2'd2, 2'd1, '0, 1'b1, 1'b0, 1'b0);
    chk(last_rdy == 1'b0, "R3", int'(last_rdy), 0);
    step(1'b1, 2'd2, 2'd2, '0, 1'b1, 1'b0, 1'b1);
    chk(last_rdy == 1'b0, "R4", int'(last_rdy), 0);
    step(1'b1, 2'd2, 2'd2, '0, 1'b1, 1'b0, 1'b0);
    chk(last_rdy == 1'b1, "R4", int'(last_rdy), 1);
    step(1'b1, 2'd3, 2'd0, '0, 1'b1, 1'b0, 1'b0);
    chk(last_rdy == 1'b0, "R2", int'(last_rdy), 0);

    // R7: issue and complete a load in one cycle, count stays at 1
    step(1'b1, 2'd0, 2'd0, 32'h11, 1'b1, 1'b1, 1'b0);
    step(1'b1, 2'd2, 2'd1, '0, 1'b1, 1'b0, 1'b0);
    chk(last_rdy == 1'b0, "R7", int'(last_rdy), 0);
    step(1'b0, 2'd0, 2'd0, '0, 1'b0, 1'b1, 1'b0);
    // R8: satisfied fence retires on first presentation
    step(1'b1, 2'd2, 2'd1, '0, 1'b1, 1'b0, 1'b0);
    chk(last_rdy == 1'b1, "R8", int'(last_rdy), 1);

    // R6: fill loads to the limit
    for (int i = 0; i < MAXC; i++) step(1'b1, 2'd0, 2'd0, PW'(i), 1'b1, 1'b0, 1'b0);
    step(1'b1, 2'd0, 2'd0, 32'h99, 1'b1, 1'b0, 1'b0);
    chk(last_iv == 1'b0, "R6", int'(last_iv), 0);
    chk(last_acc == 1'b0, "R6", int'(last_acc), 0);
    step(1'b1, 2'd1, 2'd0, 32'h98, 1'b1, 1'b0, 1'b0);
    chk(last_iv == 1'b1, "R6", int'(last_iv), 1);
    step(1'b1, 2'd0, 2'd0, 32'h99, 1'b1, 1'b1, 1'b0);
    step(1'b1, 2'd0, 2'd0, 32'h99, 1'b1, 1'b0, 1'b0);
    chk(last_iv == 1'b1, "R6", int'(last_iv), 1);

    // Random traffic, requests held until accepted
    v = 1'b0; k = 2'd0; s = 2'd0; p = '0; last_acc = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      bit cl, cs;
      int slow;
      slow = (i / 500) % 2;
      if (last_acc || !v) begin
        v = ($urandom_range(0, 9) != 0);
        k = 2'($urandom_range(0, 3));
        s = 2'($urandom_range(0, 3));
        p = $urandom;
      end
      cl = (ocnt[0] > 0) && ($urandom_range(0, slow ? 7 : 1) == 0);
      cs = (ocnt[1] > 0) && ($urandom_range(0, slow ? 7 : 1) == 0);
      step(v, k, s, p, $urandom_range(0, 3) != 0, cl, cs);
    end
    idle(2);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule